// File: doc/BRIEF.md
# Seeded Pseudo-Random Word Generator

This peripheral sits on a plain 32-bit register bus and turns a 160-bit seed into blocks of 160 pseudo-random bits. Software writes five seed words in any order. Once all five have arrived, a seeded flag appears in the status word. Software then writes a fixed command code to the control word. The engine runs its mixing function for a fixed number of clock cycles and places the result in five read-only output words. It then raises a sticky finished flag, which software polls and later clears by writing a one to that bit.

The engine keeps its 160-bit working state from one run to the next, so back-to-back runs give fresh output without reseeding. A newly completed seed load marks the seed as unused. The next run then starts from the seed words instead of from the previous state. Software can reseed at any time, for example with words taken from an earlier output block.

Top module: `prng_regblk`

## Requirements
- R1: After reset, the status word reads 0, every output word reads 0, and the seed tracking is empty.
- R2: Status bit 1 (seeded) is set only once each of the five seed words has been written. The seed words sit at byte offsets 0x140, 0x144, 0x148, 0x14C and 0x150 and may be written in any order. With fewer than five written, bit 1 reads 0.
- R3: A seed write made while bit 1 is set clears bit 1 and restarts the tracking, counting that write as the first of five. Bit 1 sets again only when the other four words have been written.
- R4: A run starts only when the control word (offset 0x00) is written with exactly 0x18, bit 1 is set and no run is in progress. Any other value, or the start code written while bit 1 is clear, has no effect.
- R5: Status bit 5 (finished) reads 0 through the first 19 clock edges after the edge that accepts the start write. It reads 1 after the 20th edge.
- R6: One run applies 20 mixing steps to the working state, held as words w0..w4. Each step computes f = w0 ^ (w0<<11) ^ (w3 & ~w2) and n = w4 ^ (w4>>19) ^ f ^ (f>>8), then shifts the words down one place (w0<=w1, w1<=w2, w2<=w3, w3<=w4) and sets w4<=n. Output word k, at offset 0x160+4k, returns wk of the final state.
- R7: A run started without a new seed load since the previous run continues from the state that run left.
- R8: A start write made while a run is in progress is ignored. The run finishes at its original time with 20 steps.
- R9: The output words do not change during a run. All five change together on the edge that sets bit 5.
- R10: Bit 5 stays set until a write to the status word (offset 0x10) has a 1 in bit 5. A status write with bit 5 at 0 leaves it set.
- R11: Bit 1 cannot be written. Writes to the output words have no effect. The seed words and the control word read as 0, and any unmapped or misaligned address reads as 0.
- R12: A seed load completed after a run makes the next run start from the new seed words rather than from the retained state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_re | input | 1 | Read strobe; read data is returned in the same cycle |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, 0 when bus_re is low |

## Verification
The bench counts the clock edges between the start write and the finished flag. A counter that is off by one shows bit 5 either one poll early or one poll late. The bench sends a second start 5 cycles into a run. A design that restarts on it finishes late, and one that reloads its state gives the wrong words. It rewrites a seed word after the seed set is complete: a tracker that only ORs in the new bits would keep bit 1 set. It runs twice without reseeding and then once after reseeding, which catches both a design that always reloads the seed and one that never does.

// File: rtl/prng_pkg.sv
package prng_pkg;
  localparam int OFS_CTRL  = 'h000;
  localparam int OFS_STAT  = 'h010;
  localparam int OFS_SEED  = 'h140;
  localparam int OFS_OUT   = 'h160;
  localparam int START_CODE = 'h18;
  localparam int STAT_SEEDED_BIT = 1;
  localparam int STAT_DONE_BIT   = 5;
endpackage

// File: rtl/prng_seed_bank.sv
module prng_seed_bank #(
  parameter int WORD_W = 32,
  parameter int NWORDS = 5,
  localparam int IDX_W = $clog2(NWORDS)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [IDX_W-1:0]               wr_idx,
  input  logic [WORD_W-1:0]              wr_data,
  output logic [NWORDS-1:0][WORD_W-1:0]  seed_words,
  output logic                           seed_ok,
  output logic                           seed_cpl
);
  logic [NWORDS-1:0] mask_q, mask_d, hit;

  assign hit = NWORDS'(1) << wr_idx;

  always_comb begin
    mask_d = mask_q;
    if (wr_en) begin
      if (&mask_q) mask_d = hit;
      else         mask_d = mask_q | hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  generate
    for (genvar g = 0; g < NWORDS; g++) begin : g_word
      logic [WORD_W-1:0] word_q;
      logic              word_en;
      assign word_en = wr_en && hit[g];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       word_q <= '0;
        else if (word_en) word_q <= wr_data;
      end
      assign seed_words[g] = word_q;
    end
  endgenerate

  assign seed_ok  = &mask_q;
  assign seed_cpl = wr_en && (&mask_d);

  // R2
  seeded_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seed_ok) |-> $past(wr_en));

  // R3
  seeded_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(seed_ok) && $past(wr_en)) |-> !seed_ok);
endmodule

// File: rtl/prng_seq.sv
module prng_seq #(
  parameter int RUN_CYCLES = 20,
  localparam int CNT_W = $clog2(RUN_CYCLES)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_cmd,
  input  logic seed_ok,
  input  logic clr_done,
  output logic go,
  output logic step_en,
  output logic fin,
  output logic busy,
  output logic done
);
  logic             busy_q, busy_d, done_q, done_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign go      = start_cmd && seed_ok && !busy_q;
  assign fin     = busy_q && (cnt_q == CNT_W'(RUN_CYCLES - 1));
  assign step_en = busy_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (go) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy_q) begin
      cnt_d = cnt_q + 1'b1;
      if (fin) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end
    end
    if (fin)           done_d = 1'b1;
    else if (clr_done) done_d = 1'b0;
    else               done_d = done_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign busy = busy_q;
  assign done = done_q;

  // R5
  run_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q);

  // R8
  cnt_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
endmodule

// File: rtl/prng_mix_core.sv
module prng_mix_core #(
  parameter int WORD_W = 32,
  parameter int NWORDS = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load,
  input  logic                          step_en,
  input  logic                          fin,
  input  logic                          seed_cpl,
  input  logic [NWORDS-1:0][WORD_W-1:0] seed_words,
  output logic [NWORDS-1:0][WORD_W-1:0] out_words
);
  typedef logic [NWORDS-1:0][WORD_W-1:0] state_t;

  function automatic state_t mix_step(input state_t s);
    logic [WORD_W-1:0] f, n;
    state_t r;
    f = s[0] ^ (s[0] << 11) ^ (s[NWORDS-2] & ~s[NWORDS-3]);
    n = s[NWORDS-1] ^ (s[NWORDS-1] >> 19) ^ f ^ (f >> 8);
    for (int k = 0; k < NWORDS - 1; k++) r[k] = s[k+1];
    r[NWORDS-1] = n;
    return r;
  endfunction

  state_t st_q, st_d, nxt, out_q, out_d;
  logic   pend_q, pend_d;

  assign nxt = mix_step(st_q);

  always_comb begin
    st_d   = st_q;
    out_d  = out_q;
    pend_d = pend_q;
    if (load) begin
      if (pend_q) st_d = seed_words;
      pend_d = 1'b0;
    end else if (step_en) begin
      st_d = nxt;
    end
    if (seed_cpl) pend_d = 1'b1;
    if (fin)      out_d  = nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= '0;
      out_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      out_q  <= out_d;
      pend_q <= pend_d;
    end
  end

  assign out_words = out_q;

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(fin) |-> $stable(out_q));
endmodule

// File: rtl/prng_regblk.sv
module prng_regblk #(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int NWORDS     = 5,
  parameter int RUN_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  import prng_pkg::*;

  localparam int IDX_W = $clog2(NWORDS);
  localparam int LSB_W = $clog2(DATA_W / 8);
  localparam int SPAN  = NWORDS * (DATA_W / 8);

  logic [1:0] rst_sync;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  logic              is_ctrl, is_stat, seed_hit, out_hit;
  logic [ADDR_W-1:0] seed_off, out_off;
  logic [IDX_W-1:0]  seed_idx, out_idx;

  assign is_ctrl  = (bus_addr == ADDR_W'(OFS_CTRL));
  assign is_stat  = (bus_addr == ADDR_W'(OFS_STAT));
  assign seed_off = bus_addr - ADDR_W'(OFS_SEED);
  assign out_off  = bus_addr - ADDR_W'(OFS_OUT);
  assign seed_hit = (bus_addr >= ADDR_W'(OFS_SEED)) && (seed_off < ADDR_W'(SPAN)) &&
                    (seed_off[LSB_W-1:0] == '0);
  assign out_hit  = (bus_addr >= ADDR_W'(OFS_OUT)) && (out_off < ADDR_W'(SPAN)) &&
                    (out_off[LSB_W-1:0] == '0);
  assign seed_idx = seed_off[LSB_W +: IDX_W];
  assign out_idx  = out_off[LSB_W +: IDX_W];

  logic                          start_cmd, clr_done, seed_wr;
  logic                          seed_ok, seed_cpl, go, step_en, fin, busy, done;
  logic [NWORDS-1:0][DATA_W-1:0] seed_words, out_words;

  assign seed_wr   = bus_we && seed_hit;
  assign start_cmd = bus_we && is_ctrl && (bus_wdata == DATA_W'(START_CODE));
  assign clr_done  = bus_we && is_stat && bus_wdata[STAT_DONE_BIT];

  prng_seed_bank #(.WORD_W(DATA_W), .NWORDS(NWORDS)) u_seed (
    .clk        (clk),
    .rst_n      (rst_ni),
    .wr_en      (seed_wr),
    .wr_idx     (seed_idx),
    .wr_data    (bus_wdata),
    .seed_words (seed_words),
    .seed_ok    (seed_ok),
    .seed_cpl   (seed_cpl)
  );

  prng_seq #(.RUN_CYCLES(RUN_CYCLES)) u_seq (
    .clk       (clk),
    .rst_n     (rst_ni),
    .start_cmd (start_cmd),
    .seed_ok   (seed_ok),
    .clr_done  (clr_done),
    .go        (go),
    .step_en   (step_en),
    .fin       (fin),
    .busy      (busy),
    .done      (done)
  );

  prng_mix_core #(.WORD_W(DATA_W), .NWORDS(NWORDS)) u_core (
    .clk        (clk),
    .rst_n      (rst_ni),
    .load       (go),
    .step_en    (step_en),
    .fin        (fin),
    .seed_cpl   (seed_cpl),
    .seed_words (seed_words),
    .out_words  (out_words)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_re) begin
      if (is_stat) begin
        bus_rdata[STAT_SEEDED_BIT] = seed_ok;
        bus_rdata[STAT_DONE_BIT]   = done;
      end else if (out_hit) begin
        for (int k = 0; k < NWORDS; k++)
          if (out_idx == IDX_W'(k)) bus_rdata = out_words[k];
      end
    end
  end

  // R10
  done_clr_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(done) |-> $past(bus_we && (bus_addr == ADDR_W'(OFS_STAT)) && bus_wdata[STAT_DONE_BIT]));

  // R4
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(busy) |-> $past(seed_ok));
endmodule

// File: tb/prng_regblk_bench.sv
module prng_regblk_bench;
  localparam int NW = 5;
  localparam logic [31:0] S0 = 32'h1234_5678, S1 = 32'h9ABC_DEF0, S2 = 32'h0F1E_2D3C,
                          S3 = 32'h4B5A_6978, S4 = 32'h8796_A5B4;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1;
  localparam int NV = 26;

  // fields: op, addr, data, expected, requirement number
  localparam logic [81:0] VEC [NV] = '{
    {OP_RD, 12'h010, 32'h0, 32'h0, 4'd1},          // R1 status clear
    {OP_RD, 12'h160, 32'h0, 32'h0, 4'd1},          // R1 output 0
    {OP_RD, 12'h170, 32'h0, 32'h0, 4'd1},          // R1 output 4
    {OP_WR, 12'h148, S2,    32'h0, 4'd2},          // R2 any order
    {OP_WR, 12'h140, S0,    32'h0, 4'd2},
    {OP_WR, 12'h150, S4,    32'h0, 4'd2},
    {OP_RD, 12'h010, 32'h0, 32'h0, 4'd2},          // R2 three of five
    {OP_WR, 12'h144, S1,    32'h0, 4'd2},
    {OP_WR, 12'h14C, S3,    32'h0, 4'd2},
    {OP_RD, 12'h010, 32'h0, 32'h2, 4'd2},          // R2 all five
    {OP_RD, 12'h144, 32'h0, 32'h0, 4'd11},         // R11 seed reads zero
    {OP_WR, 12'h14C, S3,    32'h0, 4'd3},          // R3 rewrite after complete
    {OP_RD, 12'h010, 32'h0, 32'h0, 4'd3},
    {OP_WR, 12'h140, S0,    32'h0, 4'd3},
    {OP_WR, 12'h144, S1,    32'h0, 4'd3},
    {OP_WR, 12'h148, S2,    32'h0, 4'd3},
    {OP_RD, 12'h010, 32'h0, 32'h0, 4'd3},          // R3 four of restarted five
    {OP_WR, 12'h150, S4,    32'h0, 4'd3},
    {OP_RD, 12'h010, 32'h0, 32'h2, 4'd3},
    {OP_WR, 12'h010, 32'hFFFF_FFFF, 32'h0, 4'd11}, // R11 status write
    {OP_RD, 12'h010, 32'h0, 32'h2, 4'd11},
    {OP_WR, 12'h164, 32'hDEAD_BEEF, 32'h0, 4'd11}, // R11 output write
    {OP_RD, 12'h164, 32'h0, 32'h0, 4'd11},
    {OP_RD, 12'h004, 32'h0, 32'h0, 4'd11},         // R11 unmapped
    {OP_RD, 12'h141, 32'h0, 32'h0, 4'd11},         // R11 misaligned
    {OP_RD, 12'h000, 32'h0, 32'h0, 4'd11}          // R11 control reads zero
  };

  logic        clk, rst_n, bus_we, bus_re;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  int tests, fails;
  bit finished;

  prng_regblk u_prng_regblk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef logic [NW-1:0][31:0] st_t;

  function automatic st_t model_step(input st_t s);
    logic [31:0] f, n;
    st_t r;
    f = s[0] ^ (s[0] << 11) ^ (s[3] & ~s[2]);
    n = s[4] ^ (s[4] >> 19) ^ f ^ (f >> 8);
    r = {n, s[4], s[3], s[2], s[1]};
    return r;
  endfunction

  function automatic st_t model_run(input st_t s);
    st_t r = s;
    for (int i = 0; i < 20; i++) r = model_step(r);
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    bus_re = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    bus_re = 1'b0;
  endtask

  task automatic check_rd(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    bus_rd(a, v);
    check(req, v, exp);
  endtask

  task automatic check_outs(input string req, input st_t exp);
    for (int k = 0; k < NW; k++) check_rd(req, 12'(12'h160 + 4 * k), exp[k]);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    st_t exp_st, t_seed;
    logic [31:0] v;
    tests = 0; fails = 0; finished = 0;
    bus_we = 0; bus_re = 0; bus_addr = '0; bus_wdata = '0;
    do_reset();

    for (int i = 0; i < NV; i++) begin
      logic [81:0] e;
      e = VEC[i];
      if (e[81:80] == OP_WR) bus_wr(e[79:68], e[67:36]);
      else check_rd($sformatf("R%0d vec %0d", e[3:0], i), e[79:68], e[35:4]);
    end

    // R4: wrong code with seed loaded does nothing
    bus_wr(12'h000, 32'h17);
    repeat (25) @(negedge clk);
    check_rd("R4 bad code", 12'h010, 32'h2);

    // R5 R6 R9: first run from fresh seed
    bus_wr(12'h000, 32'h18);
    check_rd("R9 outputs held during run", 12'h160, 32'h0);
    repeat (19) @(negedge clk);
    check_rd("R5 not yet done", 12'h010, 32'h2);
    @(negedge clk);
    check_rd("R5 done after 20", 12'h010, 32'h22);
    exp_st = model_run({S4, S3, S2, S1, S0});
    check_outs("R6 first block", exp_st);

    // R10: write-one-to-clear
    bus_wr(12'h010, 32'h0000_0002);
    check_rd("R10 zero bit keeps done", 12'h010, 32'h22);
    bus_wr(12'h010, 32'h0000_0020);
    check_rd("R10 cleared", 12'h010, 32'h2);

    // R7 R8: continue state, second start mid-run ignored
    bus_wr(12'h000, 32'h18);
    repeat (4) @(negedge clk);
    bus_wr(12'h000, 32'h18);
    repeat (14) @(negedge clk);
    check_rd("R8 not yet done", 12'h010, 32'h2);
    @(negedge clk);
    check_rd("R8 done on time", 12'h010, 32'h22);
    exp_st = model_run(exp_st);
    check_outs("R7 continued block", exp_st);

    // R12: reseed from previous output
    t_seed = exp_st;
    bus_wr(12'h010, 32'h20);
    for (int k = 0; k < NW; k++) bus_wr(12'(12'h140 + 4 * k), t_seed[k]);
    check_rd("R12 reseeded flag", 12'h010, 32'h2);
    bus_wr(12'h000, 32'h18);
    repeat (20) @(negedge clk);
    check_rd("R12 done", 12'h010, 32'h22);
    check_outs("R12 block from new seed", model_run(t_seed));

    // R1: reset clears everything; R4: start without seed ignored
    do_reset();
    check_rd("R1 status after reset", 12'h010, 32'h0);
    check_rd("R1 output after reset", 12'h16C, 32'h0);
    bus_wr(12'h000, 32'h18);
    repeat (25) @(negedge clk);
    check_rd("R4 unseeded start", 12'h010, 32'h0);
    bus_rd(12'h160, v);
    check("R4 outputs unchanged", v, 32'h0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule